// File: doc/BRIEF.md
# GPIO Interrupt Detect and Route

This block turns a set of already-synchronized general-purpose input lines into interrupt requests. Every line has its own enable, trigger-type and active-sense setting. A qualifying event sets a sticky per-line pending bit. Each pending bit that is also enabled is steered onto one of 32 request outputs. Software reads the pending bits and acknowledges them by writing ones.

The enable and trigger-type bits arrive as plain inputs from the surrounding register core. The active-sense register, the pending register and the four route registers live in this block. They are reached through a simple word-wide write strobe and a combinational read port, whose address decode the register core shares. A build-time parameter picks the routing scheme:
- value 0: one request per line;
- value 1: a single shared request;
- any other value: a programmable byte entry per line.

Top module: `gpio_irq_top`

## Requirements
- R1: With its trigger-type bit at 1 a line is edge-sensitive. Sense bit 1 sets the pending bit on a 0-to-1 change of the input between two consecutive clock edges, and sense bit 0 sets it on a 1-to-0 change. The pending bit is readable from the next cycle.
- R2: With its trigger-type bit at 0 a line is level-sensitive. The pending bit is set on every clock edge at which the input equals the sense bit (1 = high, 0 = low). Once the input leaves that level, the bit can be cleared.
- R3: A line whose enable bit is 0 never sets its pending bit. A pending bit whose enable is 0 drives no request line.
- R4: Pending bits read at byte address 0x44, bit n for line n. Writing that address clears each bit written as 1 and leaves bits written as 0 unchanged.
- R5: When a hardware set and a software clear hit the same pending bit in one cycle, the bit ends up set.
- R6: The sense register is at byte address 0x10. Bits of lines outside the IRQ_CAP parameter always read 0, even after ones are written, and such lines never set a pending bit.
- R7: Route registers k = 0..3 sit at byte addresses 0x20 + 4k and read back all 32 written bits. Line 4k+i uses bits [(3-i)*8+4 : (3-i)*8] of register k as its request number; the upper three bits of the byte are ignored.
- R8: Each request line is the OR of the lines that are pending, enabled and routed to it. Routing depends on IRQ_GEN: 0 sends line n to request n, 1 sends every line to request 0, and any other value uses the R7 entry.
- R9: After reset the pending, sense and route registers read 0, and all request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPIN | Synchronized line values |
| mask_i | input | NPIN | Per-line interrupt enable |
| edge_i | input | NPIN | Per-line trigger type, 1 = edge, 0 = level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | 32 | Interrupt request lines |

## Verification
A vector table walks one line through every pairing of trigger type and sense with a prior and a current input value. This separates a true rising or falling edge from a steady level, and the selected level from the opposite one. Directed cases follow:
- enabled and disabled lines, to separate flag gating from request gating;
- partial acknowledge patterns, to show that only the written bits clear;
- a clear issued while a level is still active, to show that the set wins;
- probing sense bits on incapable lines;
- two lines routed by distinct route entries, whose requests are compared across the three routing schemes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int          NREQ     = 32;
  localparam int          AW       = 8;
  localparam logic [7:0]  ADR_SENSE = 8'h10;
  localparam logic [7:0]  ADR_ROUTE = 8'h20;
  localparam logic [7:0]  ADR_PEND  = 8'h44;

  // Request number for slot i (0..3) of a route word; slot 0 is the top byte.
  function automatic logic [4:0] route_entry(input logic [31:0] word, input int slot);
    return word[8*(3-slot) +: 5];
  endfunction
endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int          NPIN    = 16,
  parameter logic [31:0] IRQ_CAP = 32'h0000_FF0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] mask_i,
  input  logic [NPIN-1:0] sense_i,
  input  logic [NPIN-1:0] edge_i,
  output logic [NPIN-1:0] set_o
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_i;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_line
    if (IRQ_CAP[g]) begin : g_cap
      logic rise, fall, lvl_hit, edg_hit;
      assign rise    = pin_i[g] & ~prev_q[g];
      assign fall    = ~pin_i[g] & prev_q[g];
      assign edg_hit = sense_i[g] ? rise : fall;
      assign lvl_hit = (pin_i[g] == sense_i[g]);
      assign set_o[g] = mask_i[g] & (edge_i[g] ? edg_hit : lvl_hit);
    end else begin : g_nocap
      assign set_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_irq_pending.sv
module gpio_irq_pending #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] set_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_i) | set_i;  // set dominates clear
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int NPIN    = 16,
  parameter int IRQ_GEN = 2,
  localparam int NROUTE = (NPIN + 3) / 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NROUTE-1:0]       we_i,
  input  logic [31:0]             wdata_i,
  input  logic [NPIN-1:0]         active_i,
  output logic [NROUTE-1:0][31:0] route_o,
  output logic [NREQ-1:0]         irq_o
);
  for (genvar k = 0; k < NROUTE; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     route_o[k] <= '0;
      else if (we_i[k]) route_o[k] <= wdata_i;
    end
  end

  if (IRQ_GEN == 0) begin : g_per_line
    assign irq_o = NREQ'(active_i);
  end else if (IRQ_GEN == 1) begin : g_shared
    assign irq_o = {{(NREQ-1){1'b0}}, |active_i};
  end else begin : g_mapped
    always_comb begin
      irq_o = '0;
      for (int p = 0; p < NPIN; p++) begin
        irq_o[route_entry(route_o[p/4], p%4)] =
          irq_o[route_entry(route_o[p/4], p%4)] | active_i[p];
      end
    end
  end
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int          NPIN    = 16,
  parameter int          IRQ_GEN = 2,
  parameter logic [31:0] IRQ_CAP = 32'h0000_FF0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] mask_i,
  input  logic [NPIN-1:0] edge_i,
  input  logic            wr_en_i,
  input  logic [7:0]      wr_addr_i,
  input  logic [31:0]     wr_data_i,
  input  logic [7:0]      rd_addr_i,
  output logic [31:0]     rd_data_o,
  output logic [31:0]     irq_o
);
  localparam int NROUTE = (NPIN + 3) / 4;
  localparam logic [NPIN-1:0] CAPM = IRQ_CAP[NPIN-1:0];

  logic [NPIN-1:0]         sense_q;
  logic [NPIN-1:0]         set_vec;
  logic [NPIN-1:0]         clr_vec;
  logic [NPIN-1:0]         pend_q;
  logic [NROUTE-1:0]       route_we;
  logic [NROUTE-1:0][31:0] route_q;

  // Sense register: incapable lines are held at 0 (R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sense_q <= '0;
    else if (wr_en_i && wr_addr_i == ADR_SENSE) sense_q <= wr_data_i[NPIN-1:0] & CAPM;
  end

  assign clr_vec = (wr_en_i && wr_addr_i == ADR_PEND) ? wr_data_i[NPIN-1:0] : '0;

  always_comb begin
    for (int k = 0; k < NROUTE; k++)
      route_we[k] = wr_en_i && (wr_addr_i == AW'(ADR_ROUTE + 8'(4*k)));
  end

  gpio_irq_detect #(.NPIN(NPIN), .IRQ_CAP(IRQ_CAP)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mask_i(mask_i),
    .sense_i(sense_q), .edge_i(edge_i), .set_o(set_vec)
  );

  gpio_irq_pending #(.NPIN(NPIN)) u_pending (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .pend_o(pend_q)
  );

  gpio_irq_route #(.NPIN(NPIN), .IRQ_GEN(IRQ_GEN)) u_route (
    .clk(clk), .rst_n(rst_n), .we_i(route_we), .wdata_i(wr_data_i),
    .active_i(pend_q & mask_i), .route_o(route_q), .irq_o(irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADR_SENSE)     rd_data_o = 32'(sense_q);
    else if (rd_addr_i == ADR_PEND) rd_data_o = 32'(pend_q);
    else begin
      for (int k = 0; k < NROUTE; k++)
        if (rd_addr_i == AW'(ADR_ROUTE + 8'(4*k))) rd_data_o = route_q[k];
    end
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int          NPIN    = 16,
  parameter logic [31:0] IRQ_CAP = 32'h0000_FF0F
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] mask_i,
  input logic            wr_en_i,
  input logic [7:0]      wr_addr_i,
  input logic [31:0]     wr_data_i,
  input logic [7:0]      rd_addr_i,
  input logic [31:0]     rd_data_o,
  input logic [31:0]     irq_o,
  input logic [NPIN-1:0] set_vec,
  input logic [NPIN-1:0] pend_q
);
  p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec & ~mask_i) == '0);

  p_set_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == ADR_PEND) |=>
      ((pend_q & $past(wr_data_i[NPIN-1:0]) & ~$past(set_vec)) == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  p_sense_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == ADR_SENSE) |-> ((rd_data_o & ~IRQ_CAP) == 32'h0));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & mask_i) == '0) |-> (irq_o == 32'h0));
endmodule

bind gpio_irq_top gpio_irq_chk #(.NPIN(NPIN), .IRQ_CAP(IRQ_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_i(mask_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o), .irq_o(irq_o), .set_vec(set_vec), .pend_q(pend_q)
);

// File: tb/gpio_irq_top_tb.sv
`timescale 1ns/1ps
module gpio_irq_top_tb;
  localparam int NPIN = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIN-1:0] pin = '0, mask = '0, edg = '0;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_addr = '0, rd_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [31:0]     rd_data, irq, rd_m0, irq_m0, rd_m1, irq_m1;
  int              n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_irq_top #(.NPIN(NPIN), .IRQ_GEN(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .mask_i(mask), .edge_i(edg),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq));
  gpio_irq_top #(.NPIN(NPIN), .IRQ_GEN(0)) u_dut_m0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .mask_i(mask), .edge_i(edg),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_m0), .irq_o(irq_m0));
  gpio_irq_top #(.NPIN(NPIN), .IRQ_GEN(1)) u_dut_m1 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .mask_i(mask), .edge_i(edg),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_m1), .irq_o(irq_m1));

  // {edge, sense, prior value, current value, expected pending} for line 0
  localparam logic [4:0] VEC [8] = '{
    5'b11011, 5'b11100, 5'b11110, 5'b10101,
    5'b10010, 5'b01011, 5'b01100, 5'b00101};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R9 reset state
    rd(8'h44, d); chk("R9 pending", d, 0);
    rd(8'h10, d); chk("R9 sense", d, 0);
    for (int k = 0; k < 4; k++) begin
      rd(8'(8'h20 + 4*k), d); chk("R9 route", d, 0);
    end
    chk("R9 irq", irq, 0);

    // Vector table: R1 edge rows, R2 level rows, request on line 0 (R8)
    for (int i = 0; i < 8; i++) begin
      logic [4:0] e;
      e = VEC[i];
      mask = '0; pin[0] = e[2]; edg = {NPIN{e[4]}};
      wr(8'h10, {31'b0, e[3]});
      wr(8'h44, 32'hFFFF);
      mask = 16'h0001; pin[0] = e[1];
      tick();
      rd(8'h44, d);
      chk(e[4] ? "R1 edge pending" : "R2 level pending", d & 1, {31'b0, e[0]});
      chk("R8 routed line 0", {31'b0, irq[0]}, {31'b0, e[0]});
    end

    // R3 enable gating
    mask = '0; pin = '0; edg = '1;
    wr(8'h10, 32'h000F);
    wr(8'h44, 32'hFFFF);
    pin[0] = 1'b1; tick();
    rd(8'h44, d); chk("R3 disabled edge", d, 0);
    pin = '0; tick();
    mask = 16'h0001; pin[0] = 1'b1; tick();
    rd(8'h44, d); chk("R3 enabled edge", d & 1, 1);
    mask = '0; tick();
    chk("R3 request gated", irq, 0);
    rd(8'h44, d); chk("R3 flag kept", d & 1, 1);

    // R4 partial acknowledge
    wr(8'h44, 32'hFFFF);
    mask = 16'h0003; pin = '0; tick();
    pin = 16'h0003; tick();
    rd(8'h44, d); chk("R4 two pending", d, 32'h3);
    wr(8'h44, 32'h1);
    rd(8'h44, d); chk("R4 one cleared", d, 32'h2);

    // R5 set wins over clear; R2 clear after level leaves
    edg = '0; mask = 16'h0001; tick();
    wr(8'h44, 32'h1);
    rd(8'h44, d); chk("R5 set beats clear", d & 1, 1);
    pin = '0; tick();
    wr(8'h44, 32'h1);
    rd(8'h44, d); chk("R2 cleared after level", d & 1, 0);

    // R6 capability probe
    mask = '0;
    wr(8'h10, 32'hFFFF);
    rd(8'h10, d); chk("R6 sense readback", d, 32'hFF0F);
    wr(8'h44, 32'hFFFF);
    mask = 16'h00F0; pin = '0; tick(); tick();
    rd(8'h44, d); chk("R6 incapable lines", d & 32'hF0, 0);

    // R7 route registers, R8 schemes
    mask = '0; edg = '1;
    wr(8'h44, 32'hFFFF);
    wr(8'h20, 32'hE500_001F);
    rd(8'h20, d); chk("R7 route0 readback", d, 32'hE500_001F);
    wr(8'h2C, 32'h0102_0304);
    rd(8'h2C, d); chk("R7 route3 readback", d, 32'h0102_0304);
    wr(8'h10, 32'h000F);
    mask = 16'h0009; pin = '0; tick();
    pin = 16'h0009; tick();
    chk("R7 mapped requests", irq, 32'h8000_0020);
    chk("R8 per-line requests", irq_m0, 32'h0000_0009);
    chk("R8 shared request", irq_m1, 32'h0000_0001);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule